// File: doc/BRIEF.md
# Vector Lane Cipher ALU

This execute unit works on a vector of `NWORDS` 32-bit words (eight by default) and performs one cipher-oriented vector operation per accepted request. The operations are a word-by-word XOR of two source vectors, a right rotation of selected words, a byte-wise doubling in a programmable binary field, a byte-matrix transpose, and multi-word shifts toward either end of the vector. The shifts pass a word through a carry register, so long operands can be processed in slices.

A controller presents an opcode, an amount, a per-word condition mask and up to two source vectors, and pulses `in_valid`. On the next clock edge the unit registers the result vector and the carry word, and it raises `out_valid` for one cycle. The condition mask has two uses. For rotations it selects which words rotate. For the field doubling its low byte is the reduction constant, so any degree-8 field can be used.

Top module: `vca_alu`

## Requirements
- R1: Opcode 0 (XOR): every result word equals the XOR of the matching words of `src_a` and `src_b`.
- R2: Opcode 1 (conditional rotate): result word i is word i of `src_a` rotated right by `amount` bits when `cond[i]` is 1, and an unchanged copy of that word when `cond[i]` is 0. Word i occupies bits [32i+31:32i].
- R3: A rotate amount of 0 leaves a word unchanged. For a word whose bytes are (a,b,c,d) from most to least significant, amounts 8, 16 and 24 give (d,a,b,c), (c,d,a,b) and (b,c,d,a).
- R4: Opcode 2 (field doubling): each byte of `src_a` is shifted left by one bit. If the bit shifted out was 1, the byte is XORed with `cond[7:0]`. Bit 8 of the polynomial is implied, so `cond[7:0]` = 0x1B gives the 0x11B field. This needs `NWORDS` of at least 8.
- R5: Opcode 3 (transpose) with `amount` = 0 copies `src_a` to the result.
- R6: Opcode 3 with a nonzero `amount` treats `src_a` as a matrix of 4 rows by `NWORDS` columns, where row r of column c is byte r of word c. It writes the matrix out row by row: result byte r·NWORDS+c equals source byte 4c+r. Byte k of the vector is bits [8k+7:8k].
- R7: Opcode 4 (shift left by n words, n = `amount`): result word i is source word i−n for i ≥ n and zero below that. The carry takes source word NWORDS−n. For n = 0 the result is a copy and the carry is kept. For n > NWORDS the result and the carry are zero.
- R8: Opcode 5 (shift right by n words): result word i is source word i+n while i+n < NWORDS. Word NWORDS−n receives the old carry, and words above it are zero. The carry takes source word n−1. For n = 0 the result is a copy and the carry is kept. For n > NWORDS the result and the carry are zero.
- R9: Opcodes 6 and 7 give an all-zero result. Every opcode other than 4 and 5 leaves the carry unchanged.
- R10: The result and the carry appear on the clock edge after `in_valid` is sampled high, with `out_valid` high for exactly that cycle. While `in_valid` is low, the result and the carry hold.
- R11: Reset (`rst_n` low) clears the result, the carry and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation select |
| amount | input | 5 | Bit rotate amount, word shift count, or transpose enable |
| cond | input | NWORDS | Per-word rotate mask; low byte is the reduction constant |
| src_a | input | 32·NWORDS | First source vector |
| src_b | input | 32·NWORDS | Second source vector (XOR only) |
| result | output | 32·NWORDS | Registered result vector |
| carry_word | output | 32 | Registered carry word |
| out_valid | output | 1 | Result strobe |

## Verification
A right word shift both reads the carry, which it inserts at the top of the vector, and writes the carry with the word that leaves the low end, all in the same cycle. The bench issues a left shift and then a right shift on consecutive clocks with no idle cycle between them. The second request therefore sees a carry that was registered only one edge earlier. The bench's own model predicts the inserted word from the first shift's outgoing word and the new carry from the second shift's low words, and it compares both with the registered outputs.

// File: rtl/vca_pkg.sv
package vca_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int WBYTES  = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    OP_XOR    = 3'd0,
    OP_ROTR   = 3'd1,
    OP_XTIME  = 3'd2,
    OP_TRANSP = 3'd3,
    OP_SHL    = 3'd4,
    OP_SHR    = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } vca_op_e;

  function automatic logic [WORD_W-1:0] rotr_word(input logic [WORD_W-1:0] w,
                                                  input logic [4:0] n);
    logic [5:0] back;
    back = 6'd32 - {1'b0, n};
    return (w >> n) | (w << back);
  endfunction

  function automatic logic [BYTE_W-1:0] dbl_byte(input logic [BYTE_W-1:0] b,
                                                 input logic [BYTE_W-1:0] red);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? red : '0);
  endfunction

endpackage

// File: rtl/vca_rot_unit.sv
module vca_rot_unit
  import vca_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic [NWORDS*WORD_W-1:0] src,
  input  logic [NWORDS-1:0]        mask,
  input  logic [4:0]               amt,
  output logic [NWORDS*WORD_W-1:0] res
);

  for (genvar gw = 0; gw < NWORDS; gw++) begin : g_word
    logic [WORD_W-1:0] w_in;
    assign w_in = src[gw*WORD_W +: WORD_W];
    assign res[gw*WORD_W +: WORD_W] = mask[gw] ? rotr_word(w_in, amt) : w_in;
  end

endmodule

// File: rtl/vca_gf_unit.sv
module vca_gf_unit
  import vca_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic [NWORDS*WORD_W-1:0] src,
  input  logic [BYTE_W-1:0]        red,
  output logic [NWORDS*WORD_W-1:0] res
);

  localparam int NBYTES = NWORDS * WBYTES;

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    assign res[gb*BYTE_W +: BYTE_W] = dbl_byte(src[gb*BYTE_W +: BYTE_W], red);
  end

endmodule

// File: rtl/vca_transpose.sv
module vca_transpose
  import vca_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic [NWORDS*WORD_W-1:0] src,
  input  logic                     en,
  output logic [NWORDS*WORD_W-1:0] res
);

  localparam int NBYTES = NWORDS * WBYTES;

  for (genvar gf = 0; gf < NBYTES; gf++) begin : g_pos
    localparam int ROW = gf / NWORDS;
    localparam int COL = gf % NWORDS;
    localparam int SRC = COL * WBYTES + ROW;
    assign res[gf*BYTE_W +: BYTE_W] = en ? src[SRC*BYTE_W +: BYTE_W]
                                         : src[gf*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/vca_word_shift.sv
module vca_word_shift
  import vca_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic [NWORDS*WORD_W-1:0] src,
  input  logic [4:0]               amt,
  input  logic [WORD_W-1:0]        car_in,
  output logic [NWORDS*WORD_W-1:0] shl_res,
  output logic [WORD_W-1:0]        shl_car,
  output logic [NWORDS*WORD_W-1:0] shr_res,
  output logic [WORD_W-1:0]        shr_car
);

  int  n;
  logic in_range;

  assign n        = int'(amt);
  assign in_range = (n <= NWORDS);

  always_comb begin
    shl_res = '0;
    shr_res = '0;
    shl_car = '0;
    shr_car = '0;
    if (in_range) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (i >= n)
          shl_res[i*WORD_W +: WORD_W] = src[(i-n)*WORD_W +: WORD_W];
        if (i + n < NWORDS)
          shr_res[i*WORD_W +: WORD_W] = src[(i+n)*WORD_W +: WORD_W];
        else if (i + n == NWORDS)
          shr_res[i*WORD_W +: WORD_W] = car_in;
      end
      if (n != 0) begin
        shl_car = src[(NWORDS-n)*WORD_W +: WORD_W];
        shr_car = src[(n-1)*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/vca_alu.sv
module vca_alu
  import vca_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [2:0]               opcode,
  input  logic [4:0]               amount,
  input  logic [NWORDS-1:0]        cond,
  input  logic [NWORDS*32-1:0]     src_a,
  input  logic [NWORDS*32-1:0]     src_b,
  output logic [NWORDS*32-1:0]     result,
  output logic [31:0]              carry_word,
  output logic                     out_valid
);

  localparam int VEC_W = NWORDS * WORD_W;

  vca_op_e          op;
  logic [VEC_W-1:0] rot_res, gf_res, tr_res, shl_res, shr_res;
  logic [WORD_W-1:0] shl_car, shr_car;
  logic [VEC_W-1:0] res_next;
  logic [WORD_W-1:0] car_next;
  logic              is_shift;
  logic              car_we;

  assign op = vca_op_e'(opcode);

  vca_rot_unit #(.NWORDS(NWORDS)) u_rot (
    .src (src_a),
    .mask(cond),
    .amt (amount),
    .res (rot_res)
  );

  vca_gf_unit #(.NWORDS(NWORDS)) u_gf (
    .src(src_a),
    .red(cond[BYTE_W-1:0]),
    .res(gf_res)
  );

  vca_transpose #(.NWORDS(NWORDS)) u_tr (
    .src(src_a),
    .en (amount != 5'd0),
    .res(tr_res)
  );

  vca_word_shift #(.NWORDS(NWORDS)) u_sh (
    .src    (src_a),
    .amt    (amount),
    .car_in (carry_word),
    .shl_res(shl_res),
    .shl_car(shl_car),
    .shr_res(shr_res),
    .shr_car(shr_car)
  );

  // named event: carry register is rewritten by this request
  assign is_shift = (op == OP_SHL) || (op == OP_SHR);
  assign car_we   = in_valid && is_shift && (amount != 5'd0);

  always_comb begin
    case (op)
      OP_XOR:    res_next = src_a ^ src_b;
      OP_ROTR:   res_next = rot_res;
      OP_XTIME:  res_next = gf_res;
      OP_TRANSP: res_next = tr_res;
      OP_SHL:    res_next = shl_res;
      OP_SHR:    res_next = shr_res;
      default:   res_next = '0;
    endcase
  end

  assign car_next = (op == OP_SHL) ? shl_car : shr_car;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      carry_word <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_next;
      if (car_we)   carry_word <= car_next;
    end
  end

endmodule

// File: rtl/vca_alu_chk.sv
module vca_alu_chk
  import vca_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [2:0]           opcode,
  input logic [4:0]           amount,
  input logic [NWORDS-1:0]    cond,
  input logic [NWORDS*32-1:0] src_a,
  input logic [NWORDS*32-1:0] result,
  input logic [31:0]          carry_word,
  input logic                 out_valid
);

  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_word)));

  assert_carry_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode != 3'd4 && opcode != 3'd5) |=> $stable(carry_word));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[2] && opcode[1]) |=> (result == '0));

  assert_rot_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd1 && cond == '0) |=> (result == $past(src_a)));

  assert_transp_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd3 && amount == 5'd0) |=> (result == $past(src_a)));

  assert_shl_one_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd4 && amount == 5'd1)
      |=> (carry_word == $past(src_a[NWORDS*32-1 -: 32])));

endmodule

bind vca_alu vca_alu_chk #(.NWORDS(NWORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .amount    (amount),
  .cond      (cond),
  .src_a     (src_a),
  .result    (result),
  .carry_word(carry_word),
  .out_valid (out_valid)
);

// File: tb/vca_alu_tb.sv
module vca_alu_tb;

  localparam int NW = 8;
  localparam int VW = NW * 32;
  localparam int NT = 18;

  localparam logic [2:0] T_OP [NT] = '{3'd0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3,
                                       3'd3, 3'd4, 3'd5, 3'd4, 3'd5, 3'd4, 3'd6, 3'd7, 3'd5};
  localparam logic [4:0] T_N  [NT] = '{5'd0, 5'd8, 5'd16, 5'd24, 5'd0, 5'd13, 5'd0, 5'd0, 5'd0,
                                       5'd1, 5'd1, 5'd1, 5'd3, 5'd8, 5'd9, 5'd2, 5'd0, 5'd0};
  localparam logic [7:0] T_C  [NT] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'hFF, 8'h81, 8'h1B, 8'h4D, 8'h00,
                                       8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    opcode;
  logic [4:0]    amount;
  logic [NW-1:0] cond;
  logic [VW-1:0] src_a, src_b;
  logic [VW-1:0] result;
  logic [31:0]   carry_word;
  logic          out_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_car = '0;

  always #5 clk = ~clk;

  vca_alu #(.NWORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .amount(amount),
    .cond(cond), .src_a(src_a), .src_b(src_b), .result(result),
    .carry_word(carry_word), .out_valid(out_valid)
  );

  function automatic logic [31:0] m_rotr(input logic [31:0] w, input int n);
    logic [63:0] d;
    d = {w, w} >> n;
    return d[31:0];
  endfunction

  function automatic logic [VW-1:0] pattern(input int s);
    logic [VW-1:0] v;
    for (int w = 0; w < NW; w++)
      v[w*32 +: 32] = (32'(s) * 32'h9E3779B9 + 32'(w) * 32'h7F4A7C15) ^ 32'hA5A50F0F;
    return v;
  endfunction

  task automatic model(input logic [2:0] op, input logic [4:0] n, input logic [NW-1:0] c,
                       input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [31:0] cin,
                       output logic [VW-1:0] r, output logic [31:0] cout);
    int k;
    logic [2*VW-1:0] ext;
    logic [7:0] bt, sh;
    k = int'(n);
    r = '0;
    cout = cin;
    case (op)
      3'd0: r = a ^ b;
      3'd1: for (int w = 0; w < NW; w++)
              r[w*32 +: 32] = c[w] ? m_rotr(a[w*32 +: 32], k) : a[w*32 +: 32];
      3'd2: for (int q = 0; q < NW*4; q++) begin
              bt = a[q*8 +: 8];
              sh = bt + bt;
              r[q*8 +: 8] = bt[7] ? (sh ^ c[7:0]) : sh;
            end
      3'd3: if (k == 0) r = a;
            else for (int row = 0; row < 4; row++)
              for (int col = 0; col < NW; col++)
                r[(row*NW + col)*8 +: 8] = a[(col*4 + row)*8 +: 8];
      3'd4: if (k == 0) r = a;
            else if (k > NW) cout = '0;
            else begin
              ext = {{VW{1'b0}}, a} << (k*32);
              r = ext[VW-1:0];
              cout = ext[VW +: 32];
            end
      3'd5: if (k == 0) r = a;
            else if (k > NW) cout = '0;
            else begin
              ext = {{(VW-32){1'b0}}, cin, a} >> (k*32);
              r = ext[VW-1:0];
              cout = a[(k-1)*32 +: 32];
            end
      default: r = '0;
    endcase
  endtask

  function automatic string req_of(input logic [2:0] op, input logic [4:0] n);
    case (op)
      3'd0: return "R1";
      3'd1: return (n == 0) ? "R3" : "R2";
      3'd2: return "R4";
      3'd3: return (n == 0) ? "R5" : "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [4:0] n, input logic [NW-1:0] c,
                        input logic [VW-1:0] a, input logic [VW-1:0] b, input string tag);
    logic [VW-1:0] er;
    logic [31:0] ec;
    model(op, n, c, a, b, m_car, er, ec);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; amount = n; cond = c; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec(tag, result, er);
    chk32({tag, " carry"}, carry_word, ec);
    chk32({tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
    m_car = ec;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, hold_r, er1, er2;
    logic [31:0] ec1, ec2;
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; amount = '0; cond = '0;
    src_a = '1; src_b = '1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk_vec("R11 reset", result, '0);
    chk32("R11 reset carry", carry_word, '0);
    chk32("R11 reset valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int t = 0; t < NT; t++)
      run_op(T_OP[t], T_N[t], T_C[t], pattern(t + 1), pattern(t + 101), req_of(T_OP[t], T_N[t]));

    // R3: known byte orders of a rotation
    a = pattern(55);
    a[31:0] = 32'h11223344;
    run_op(3'd1, 5'd8, 8'hFF, a, '0, "R3 rot8");
    chk32("R3 rot8 bytes", result[31:0], 32'h44112233);
    run_op(3'd1, 5'd16, 8'hFF, a, '0, "R3 rot16");
    chk32("R3 rot16 bytes", result[31:0], 32'h33441122);
    run_op(3'd1, 5'd24, 8'hFF, a, '0, "R3 rot24");
    chk32("R3 rot24 bytes", result[31:0], 32'h22334411);

    // R4: known products in the 0x11B field
    a[31:0] = 32'h57838001;
    run_op(3'd2, 5'd0, 8'h1B, a, '0, "R4 aes");
    chk32("R4 aes bytes", result[31:0], 32'hAE1D1B02);

    // R8: shift right by full width places carry in word 0
    run_op(3'd4, 5'd2, 8'h00, pattern(70), '0, "R7 pre");
    run_op(3'd5, 5'd8, 8'h00, pattern(71), '0, "R8 full");

    // back-to-back shift left then shift right: carry written then read next cycle
    model(3'd4, 5'd2, '0, pattern(80), '0, m_car, er1, ec1);
    model(3'd5, 5'd3, '0, pattern(81), '0, ec1, er2, ec2);
    @(negedge clk);
    in_valid = 1'b1; opcode = 3'd4; amount = 5'd2; src_a = pattern(80);
    @(negedge clk);
    chk_vec("R7 chain", result, er1);
    chk32("R7 chain carry", carry_word, ec1);
    opcode = 3'd5; amount = 5'd3; src_a = pattern(81);
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R8 chain", result, er2);
    chk32("R8 chain carry", carry_word, ec2);
    m_car = ec2;

    // R10: outputs hold while idle
    hold_r = result;
    src_a = pattern(90); opcode = 3'd0;
    repeat (2) @(negedge clk);
    chk_vec("R10 hold", result, hold_r);
    chk32("R10 hold carry", carry_word, m_car);
    chk32("R10 idle valid", {31'd0, out_valid}, 32'd0);

    // R9: unused opcode keeps a nonzero carry
    run_op(3'd6, 5'd1, 8'hFF, pattern(91), pattern(92), "R9 keep");

    // R11: reset after activity
    rst_n = 1'b0;
    @(negedge clk);
    chk_vec("R11 rerst", result, '0);
    chk32("R11 rerst carry", carry_word, '0);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule